// File: doc/BRIEF.md
# Register-to-Memory Byte Burst Sequencer

This block carries out the memory phase of byte-granular load and store instructions. It moves a run of bytes between a 32-entry register file of 32-bit registers and a byte-addressed data memory. The caller gives a start address, a byte count, a first register and a first byte lane within that register. The block then takes one memory byte per cycle. It steps through the lanes of each register and carries into the next register when the lane index wraps. Bytes at rising addresses land in rising lanes, which is the little-endian order.

Before any byte moves, the block checks the request. A run that would overrun the end of the register file raises an illegal-instruction fault. An access that starts at or runs into the instruction-space base address raises an access fault. When the null-trap option is enabled, an access that starts below address 4 also raises an access fault. A faulted request touches neither memory nor registers. Success is reported with a one-cycle done pulse, and the timing follows a single base cycle plus two extra cycles of memory latency. The register file read port and the memory read data are both combinational: data is valid in the same cycle as the address.

Top module: `byte_burst_seq`

## Requirements
- R1: Byte lane n of a register is bits 8n+7:8n. A store writes `rfRdData[8n+7:8n]` of the current register to memory. A load drives `rfWrLaneEn` with only bit n set, where bit n enables bits 8n+7:8n, and it places the memory byte in every lane of `rfWrData`.
- R2: Each byte cycle advances the memory address by one and the lane by one. When the lane passes 3, it returns to 0 and the register index increases by one. One byte moves in each cycle of the run.
- R3: If firstReg*4 + firstLane + byteCount > 128, the block pulses `faultIll` and makes no memory request and no register write.
- R4: With `nullTrapEn` high, a start address below 4 pulses `faultAcc` and moves nothing. With `nullTrapEn` low, the same address transfers normally.
- R5: If startAddr >= instBase, or startAddr + byteCount > instBase, the block pulses `faultAcc` and moves nothing. A run that ends exactly at instBase is legal.
- R6: When an access fault and a register-range fault both apply, only `faultAcc` is pulsed.
- R7: If the start is sampled at clock edge k, the check takes the cycle after edge k and the first byte moves in the cycle after that. `done` is high in the third cycle after the last byte cycle, which leaves two empty latency cycles between them.
- R8: A load changes only the addressed lane of each register it touches. The other lanes keep their values.
- R9: A byte count of zero with no fault gives `done` in the second cycle after the start is sampled, with no memory request.
- R10: `done`, `faultIll` and `faultAcc` are one-cycle pulses and never occur together. `busy` is high from the check cycle through the pulse cycle. A `start` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transfer (sampled while idle) |
| isLoad | input | 1 | 1 = memory to registers, 0 = registers to memory |
| startAddr | input | ADDR_W | First memory byte address |
| byteCount | input | CNT_W | Number of bytes to move |
| firstReg | input | 5 | First register index |
| firstLane | input | 2 | First byte lane in the first register |
| nullTrapEn | input | 1 | Enable the low-address trap |
| instBase | input | ADDR_W | Base address of instruction space |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Successful completion pulse |
| faultIll | output | 1 | Register-range fault pulse |
| faultAcc | output | 1 | Address fault pulse |
| rfAddr | output | 5 | Register file index |
| rfRdData | input | 32 | Register read data (combinational) |
| rfWrEn | output | 1 | Register write enable |
| rfWrLaneEn | output | 4 | Per-lane register write enables |
| rfWrData | output | 32 | Register write data |
| memReq | output | 1 | Memory byte access this cycle |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte (combinational) |

## Verification
The bench runs stores and loads that start in a middle lane and cross one or two register boundaries. A design with a wrong carry would repeat or skip a register, and a design with a bad lane mask would overwrite neighbouring bytes that must survive. It probes the register-range limit at exactly 128 and at 129, and the instruction-space check both at a run ending exactly on the base and at one byte past it. An off-by-one there would either fault on a legal access or let a byte leak into instruction space. It also covers the fault priority, a zero-length request, the null trap with the option on and off, and a second start pulsed mid-run. A design that takes that second start would show extra memory traffic or a second done.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef struct packed {
    logic load;   // capture request parameters
    logic step;   // move one byte and advance pointers
    logic xfer;   // byte cycle active
  } ctrlStrobe_t;

  typedef struct packed {
    logic faultIll;
    logic faultAcc;
    logic zeroCnt;
    logic lastByte;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_XFER,
    ST_TAIL,
    ST_FIN
  } seqState_t;

endpackage

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 8,
  parameter int NUM_REGS = 32,
  parameter int LANES    = 4,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int LANE_W  = $clog2(LANES),
  localparam int DATA_W  = LANES * 8,
  localparam int SUM_W   = CNT_W + REG_W + LANE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  input  logic              isLoad,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [REG_W-1:0]  firstReg,
  input  logic [LANE_W-1:0] firstLane,
  input  logic              nullTrapEn,
  input  logic [ADDR_W-1:0] instBase,
  output logic [REG_W-1:0]  rfAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [LANES-1:0]  rfWrLaneEn,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);

  localparam logic [SUM_W-1:0] RANGE_LIMIT = SUM_W'(NUM_REGS * LANES);

  logic [ADDR_W-1:0] addrQ, baseQ;
  logic [CNT_W-1:0]  remQ;
  logic [REG_W-1:0]  regQ;
  logic [LANE_W-1:0] laneQ;
  logic              loadQ, nullEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      baseQ   <= '0;
      remQ    <= '0;
      regQ    <= '0;
      laneQ   <= '0;
      loadQ   <= 1'b0;
      nullEnQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ   <= startAddr;
      baseQ   <= instBase;
      remQ    <= byteCount;
      regQ    <= firstReg;
      laneQ   <= firstLane;
      loadQ   <= isLoad;
      nullEnQ <= nullTrapEn;
    end else if (strobe.step) begin
      addrQ <= addrQ + 1'b1;
      remQ  <= remQ - 1'b1;
      laneQ <= laneQ + 1'b1;
      if (laneQ == LANE_W'(LANES - 1))
        regQ <= regQ + 1'b1;
    end
  end

  // request checks, evaluated on the captured parameters
  logic [SUM_W-1:0]  spanEnd;
  logic [ADDR_W:0]   addrEnd;
  logic              nullHit, spaceHit;

  always_comb begin
    spanEnd  = (SUM_W'(regQ) << LANE_W) + SUM_W'(laneQ) + SUM_W'(remQ);
    addrEnd  = {1'b0, addrQ} + (ADDR_W + 1)'(remQ);
    nullHit  = nullEnQ && (addrQ < ADDR_W'(4));
    spaceHit = (addrQ >= baseQ) || (addrEnd > {1'b0, baseQ});
    status.faultAcc = nullHit || spaceHit;
    status.faultIll = spanEnd > RANGE_LIMIT;
    status.zeroCnt  = (remQ == '0);
    status.lastByte = (remQ == CNT_W'(1));
  end

  // port drive
  always_comb begin
    rfAddr     = regQ;
    memReq     = strobe.xfer;
    memWe      = strobe.xfer && !loadQ;
    memAddr    = addrQ;
    memWdata   = rfRdData[laneQ*8 +: 8];
    rfWrEn     = strobe.xfer && loadQ;
    rfWrLaneEn = '0;
    if (strobe.xfer && loadQ)
      rfWrLaneEn[laneQ] = 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rfWrData[g*8 +: 8] = memRdata;
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int TAIL_CYCLES = 2,
  localparam int TAIL_W     = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        faultIll,
  output logic        faultAcc
);

  seqState_t         stateQ, stateD;
  logic [TAIL_W-1:0] tailQ;
  logic              illQ, accQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (start) stateD = ST_CHECK;
      ST_CHECK: begin
        if (status.faultAcc || status.faultIll || status.zeroCnt)
          stateD = ST_FIN;
        else
          stateD = ST_XFER;
      end
      ST_XFER:  if (status.lastByte) stateD = ST_TAIL;
      ST_TAIL:  if (tailQ == TAIL_W'(TAIL_CYCLES - 1)) stateD = ST_FIN;
      ST_FIN:   stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      tailQ  <= '0;
      illQ   <= 1'b0;
      accQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_TAIL) tailQ <= tailQ + 1'b1;
      else                   tailQ <= '0;
      if (stateQ == ST_IDLE) begin
        illQ <= 1'b0;
        accQ <= 1'b0;
      end else if (stateQ == ST_CHECK) begin
        accQ <= status.faultAcc;
        illQ <= status.faultIll && !status.faultAcc;
      end
    end
  end

  always_comb begin
    strobe.load = (stateQ == ST_IDLE) && start;
    strobe.step = (stateQ == ST_XFER);
    strobe.xfer = (stateQ == ST_XFER);
    busy        = (stateQ != ST_IDLE);
    done        = (stateQ == ST_FIN) && !illQ && !accQ;
    faultIll    = (stateQ == ST_FIN) && illQ;
    faultAcc    = (stateQ == ST_FIN) && accQ;
  end

endmodule

// File: rtl/byte_burst_seq.sv
module byte_burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 8,
  parameter int TAIL_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isLoad,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [4:0]        firstReg,
  input  logic [1:0]        firstLane,
  input  logic              nullTrapEn,
  input  logic [ADDR_W-1:0] instBase,
  output logic              busy,
  output logic              done,
  output logic              faultIll,
  output logic              faultAcc,
  output logic [4:0]        rfAddr,
  input  logic [31:0]       rfRdData,
  output logic              rfWrEn,
  output logic [3:0]        rfWrLaneEn,
  output logic [31:0]       rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  burst_ctrl #(.TAIL_CYCLES(TAIL_CYCLES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .status   (status),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .faultIll (faultIll),
    .faultAcc (faultAcc)
  );

  burst_dpath #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .NUM_REGS (32),
    .LANES    (4)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .status     (status),
    .isLoad     (isLoad),
    .startAddr  (startAddr),
    .byteCount  (byteCount),
    .firstReg   (firstReg),
    .firstLane  (firstLane),
    .nullTrapEn (nullTrapEn),
    .instBase   (instBase),
    .rfAddr     (rfAddr),
    .rfRdData   (rfRdData),
    .rfWrEn     (rfWrEn),
    .rfWrLaneEn (rfWrLaneEn),
    .rfWrData   (rfWrData),
    .memReq     (memReq),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata)
  );

endmodule

// File: rtl/burst_chk.sv
module burst_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              faultIll,
  input logic              faultAcc,
  input logic [4:0]        rfAddr,
  input logic              rfWrEn,
  input logic [3:0]        rfWrLaneEn,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  logic reqSeen;
  always_ff @(posedge clk) begin
    if (!rstN)                reqSeen <= 1'b0;
    else if (start && !busy)  reqSeen <= 1'b0;
    else if (memReq || rfWrEn) reqSeen <= 1'b1;
  end

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> $countones(rfWrLaneEn) == 1);  // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> memAddr == $past(memAddr) + 1'b1);  // R2

  AST_LANE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && $past(rfWrEn) && $past(rfWrLaneEn[3]))
      |-> (rfWrLaneEn[0] && rfAddr == $past(rfAddr) + 1'b1));  // R2

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (faultIll || faultAcc) |-> !reqSeen);  // R3

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(memReq, 3) && !$past(memReq, 2) && !$past(memReq)) |-> done);  // R7

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (done || faultIll || faultAcc) |=> !(done || faultIll || faultAcc));  // R10

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, faultIll, faultAcc}));  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !rfWrEn));  // R10

  AST_STORE_NO_RFWR: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> !rfWrEn);  // R1

endmodule

bind byte_burst_seq burst_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .faultIll   (faultIll),
  .faultAcc   (faultAcc),
  .rfAddr     (rfAddr),
  .rfWrEn     (rfWrEn),
  .rfWrLaneEn (rfWrLaneEn),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAddr    (memAddr)
);

// File: tb/test_byte_burst_seq.sv
`timescale 1ns/1ps
module test_byte_burst_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isLoad = 1'b0, nullTrapEn = 1'b0;
  logic [15:0] startAddr = '0, instBase = 16'h0300;
  logic [7:0]  byteCount = '0;
  logic [4:0]  firstReg = '0;
  logic [1:0]  firstLane = '0;
  logic        busy, done, faultIll, faultAcc, rfWrEn, memReq, memWe;
  logic [4:0]  rfAddr;
  logic [31:0] rfRdData, rfWrData;
  logic [3:0]  rfWrLaneEn;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, memRdata;

  logic [31:0] rf [32];
  logic [7:0]  mem [1024];

  int checks = 0, errors = 0;
  int lastCyc, nReq, nWr;
  bit lastDone, lastIll, lastAcc, afterPulse;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  byte_burst_seq i_byte_burst_seq (.*);

  assign rfRdData = rf[rfAddr];
  assign memRdata = mem[memAddr[9:0]];

  always @(posedge clk) begin
    if (memReq && memWe) mem[memAddr[9:0]] <= memWdata;
    if (rfWrEn)
      for (int i = 0; i < 4; i++)
        if (rfWrLaneEn[i]) rf[rfAddr][i*8 +: 8] <= rfWrData[i*8 +: 8];
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one transfer; optional extra start pulse at cycle 3
  task automatic runXfer(bit ld, int addr, int cnt, int rg, int ln, bit nul, bit poke);
    @(negedge clk);
    isLoad = ld; startAddr = 16'(addr); byteCount = 8'(cnt);
    firstReg = 5'(rg); firstLane = 2'(ln); nullTrapEn = nul; start = 1'b1;
    lastCyc = 0; nReq = 0; nWr = 0;
    lastDone = 0; lastIll = 0; lastAcc = 0;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c < 400; c++) begin
      if (c > 1) @(negedge clk);
      if (memReq) nReq++;
      if (rfWrEn) nWr++;
      if (poke && c == 3) begin
        start = 1'b1; startAddr = 16'h0010; byteCount = 8'd5; isLoad = 1'b0;
      end else start = 1'b0;
      if (done || faultIll || faultAcc) begin
        lastCyc = c; lastDone = done; lastIll = faultIll; lastAcc = faultAcc;
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    afterPulse = done || faultIll || faultAcc;
  endtask

  task automatic testReset();
    chk(!busy && !done && !faultIll && !faultAcc, "R10", "reset pulses/busy",
        {busy, done, faultIll, faultAcc}, 0);
    chk(!memReq && !rfWrEn, "R10", "reset port quiet", {memReq, rfWrEn}, 0);
  endtask

  task automatic testStore();
    logic [7:0] expB [7];
    int r = 5, l = 2;
    rf[5] = 32'h44332211; rf[6] = 32'h88776655; rf[7] = 32'hCCBBAA99;
    for (int i = 0; i < 8; i++) mem[16'h40 + i] = 8'hEE;
    for (int i = 0; i < 7; i++) begin
      expB[i] = rf[r][l*8 +: 8];
      l++; if (l == 4) begin l = 0; r++; end
    end
    runXfer(0, 16'h40, 7, 5, 2, 0, 0);
    for (int i = 0; i < 7; i++)
      chk(mem[16'h40 + i] == expB[i], "R1", $sformatf("store byte %0d", i),
          mem[16'h40 + i], expB[i]);
    chk(mem[16'h47] == 8'hEE, "R2", "byte after run untouched", mem[16'h47], 8'hEE);
    chk(nReq == 7, "R2", "one access per byte", nReq, 7);
    chk(lastDone && lastCyc == 11, "R7", "store done cycle", lastCyc, 11);
    chk(!afterPulse, "R10", "done single cycle", afterPulse, 0);
  endtask

  task automatic testLoad();
    for (int i = 0; i < 9; i++) mem[16'h80 + i] = 8'(8'h10 + i);
    rf[9] = 32'hA5A5A5A5; rf[10] = 32'hA5A5A5A5;
    rf[11] = 32'hA5A5A5A5; rf[12] = 32'hA5A5A5A5; rf[13] = 32'hA5A5A5A5;
    runXfer(1, 16'h80, 9, 10, 1, 0, 0);
    chk(rf[10] == 32'h121110A5, "R8", "load reg10 lane0 kept", rf[10], 32'h121110A5);
    chk(rf[11] == 32'h16151413, "R2", "load reg11 full", rf[11], 32'h16151413);
    chk(rf[12] == 32'hA5A51817, "R8", "load reg12 upper kept", rf[12], 32'hA5A51817);
    chk(rf[9] == 32'hA5A5A5A5 && rf[13] == 32'hA5A5A5A5, "R2", "neighbour regs",
        rf[13], 32'hA5A5A5A5);
    chk(lastDone && lastCyc == 13 && nWr == 9, "R7", "load done cycle", lastCyc, 13);
  endtask

  task automatic testRange();
    rf[31] = 32'h5A000000;
    mem[16'h20] = 8'h00; mem[16'h21] = 8'h00;
    runXfer(0, 16'h20, 2, 31, 3, 0, 0);
    chk(lastIll && !lastAcc && !lastDone, "R3", "129 bytes span faults",
        {lastIll, lastAcc, lastDone}, 3'b100);
    chk(nReq == 0 && lastCyc == 2, "R3", "no access on fault", nReq, 0);
    chk(mem[16'h20] == 8'h00, "R3", "memory untouched", mem[16'h20], 0);
    runXfer(0, 16'h20, 1, 31, 3, 0, 0);
    chk(lastDone && mem[16'h20] == 8'h5A, "R3", "128 span legal", mem[16'h20], 8'h5A);
  endtask

  task automatic testNull();
    rf[2] = 32'h0000C3B2;
    mem[2] = 8'h00; mem[3] = 8'h00;
    runXfer(0, 2, 2, 2, 0, 1, 0);
    chk(lastAcc && nReq == 0 && mem[2] == 8'h00, "R4", "null trap on",
        {lastAcc, nReq[3:0]}, 5'b10000);
    runXfer(0, 2, 2, 2, 0, 0, 0);
    chk(lastDone && mem[2] == 8'hB2 && mem[3] == 8'hC3, "R4", "null trap off",
        {mem[3], mem[2]}, 16'hC3B2);
  endtask

  task automatic testSpace();
    rf[4] = 32'h00007766;
    runXfer(0, 16'h02FE, 2, 4, 0, 0, 0);
    chk(lastDone && mem[16'h2FF] == 8'h77, "R5", "run ending at base legal",
        mem[16'h2FF], 8'h77);
    runXfer(0, 16'h02FE, 3, 4, 0, 0, 0);
    chk(lastAcc && nReq == 0, "R5", "run crossing base faults", lastAcc, 1);
    runXfer(1, 16'h0300, 0, 4, 0, 0, 0);
    chk(lastAcc && !lastDone, "R5", "start at base faults", lastAcc, 1);
  endtask

  task automatic testPriority();
    runXfer(0, 16'h0300, 4, 31, 3, 0, 0);
    chk(lastAcc && !lastIll, "R6", "access beats range", {lastAcc, lastIll}, 2'b10);
  endtask

  task automatic testZero();
    runXfer(1, 16'h100, 0, 0, 0, 0, 0);
    chk(lastDone && lastCyc == 2 && nReq == 0, "R9", "zero count", lastCyc, 2);
  endtask

  task automatic testBusyStart();
    rf[8] = 32'h0D0C0B0A;
    mem[16'h10] = 8'h00;
    runXfer(0, 16'h60, 4, 8, 0, 0, 1);
    chk(lastDone && lastCyc == 8 && nReq == 4, "R10", "start ignored while busy",
        nReq, 4);
    chk(mem[16'h10] == 8'h00, "R10", "no second run memory", mem[16'h10], 0);
    repeat (6) begin
      @(negedge clk);
      chk(!busy && !memReq, "R10", "stays idle", {busy, memReq}, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testStore();
    testLoad();
    testRange();
    testNull();
    testSpace();
    testPriority();
    testZero();
    testBusyStart();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule